// File: doc/BRIEF.md
# Microcoded Instruction Sequencer

This controller steps a processor through instruction fetch, decode and a multi-step execute phase. It keeps a 9-bit micro-address register that indexes a small microcode ROM, which is built as a case table. Each microword drives three bus controls: the address-bus source select, the data-bus source select and the instruction-register load. Each microword also carries an end-of-instruction flag and a next-address field. The datapath registers live outside this block. The sequencer sees only their contents, through `instr_i` and `oprnd_i`, and the memory ready handshake.

Fetch always sits at micro-address 0 and decode at micro-address 1. Decode takes the top four bits of either the instruction register or the operand register and looks up an entry micro-address in a dispatch table. Execute routines step through consecutive microwords and return to fetch once they finish. A code with no routine goes to a trap microword instead, which sets a sticky error flag.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_ni` is low, `upc_o` is 0 and `err_o` is 0. Reset acts asynchronously.
- R2: At micro-address 0 (fetch), `asel_o`=1 (instruction pointer), `dsel_o`=1 (memory) and `ir_ld_o`=`rdy_i`. With `rdy_i` high, the next micro-address is 1.
- R3: At fetch with `rdy_i` low, `ir_ld_o` is 0 and the micro-address stays 0 on the next cycle.
- R4: At micro-address 1 (decode), `asel_o`=0 (none), `dsel_o`=0 (none), `ir_ld_o`=0 and `eoi_o`=0. The dispatch code is bits [31:28] of `instr_i` when `dec_src_i`=0, and bits [31:28] of `oprnd_i` when `dec_src_i`=1.
- R5: A dispatch code c below 12 sends decode to entry micro-address 0x010 + 4*c.
- R6: The routine for code c has (c mod 4)+1 steps at consecutive micro-addresses. Every execute step drives `asel_o`=2 (workspace pointer). It drives `dsel_o`=2 (A register) on every step except the last, which drives 3 (result).
- R7: The last execute step drives `eoi_o`=1, and the micro-address returns to 0 on the next cycle. `eoi_o` is 0 on all other execute steps. A single-step routine therefore returns to fetch right after its only step.
- R8: Codes 12 to 15 go to the trap microword at 0x1F0. It drives `asel_o`=0, `dsel_o`=0 and `eoi_o`=1, then returns to fetch. From the next cycle, `err_o` is 1 and stays 1 until reset.
- R9: `rdy_i` has no effect at decode or execute micro-addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rdy_i | input | 1 | Memory ready for the fetch read |
| dec_src_i | input | 1 | Dispatch source: 0 instruction register, 1 operand register |
| instr_i | input | 32 | Instruction register contents |
| oprnd_i | input | 32 | Operand register contents |
| upc_o | output | 9 | Current micro-address |
| asel_o | output | 2 | Address bus source: 0 none, 1 instr pointer, 2 workspace ptr, 3 operand reg |
| dsel_o | output | 2 | Data bus source: 0 none, 1 memory, 2 A register, 3 result |
| ir_ld_o | output | 1 | Instruction register load enable |
| eoi_o | output | 1 | Last microword of the current instruction |
| err_o | output | 1 | Sticky flag: an unused dispatch code was decoded |

## Verification
The assertions assume that `instr_i`, `oprnd_i` and `dec_src_i` stay stable from the fetch cycle through decode. They also assume that `rdy_i` is only meaningful at the fetch step. The stimulus changes the register contents and the dispatch source only just after the edge that enters fetch. It holds them there until the instruction's last microword has retired. It lowers `rdy_i` both to stall fetch for several cycles and, separately, during execute, to show that ready is ignored outside fetch. Every one of the sixteen codes is decoded from the instruction register. Several codes are also decoded from the operand register, with a different code placed in the instruction register.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned UA_W = 9;

  typedef enum logic [1:0] {
    ASRC_NONE = 2'd0,
    ASRC_IPTR = 2'd1,
    ASRC_WPTR = 2'd2,
    ASRC_OREG = 2'd3
  } asrc_e;

  typedef enum logic [1:0] {
    DSRC_NONE = 2'd0,
    DSRC_MEM  = 2'd1,
    DSRC_AREG = 2'd2,
    DSRC_RES  = 2'd3
  } dsrc_e;

  typedef struct packed {
    asrc_e            asel;
    dsrc_e            dsel;
    logic             ir_ld;
    logic             eoi;
    logic             disp;
    logic             trap;
    logic [UA_W-1:0]  nxt;
  } uword_t;
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int unsigned               N_USED     = 12,
  parameter int unsigned               ENTRY_BASE = 16,
  parameter int unsigned               STRIDE     = 4,
  parameter logic [useq_pkg::UA_W-1:0] TRAP_ADDR  = 9'h1F0
) (
  input  logic [UA_W-1:0] upc_i,
  output uword_t          word_o
);
  localparam int unsigned EXEC_END = ENTRY_BASE + N_USED * STRIDE;

  int unsigned rel;
  int unsigned code;
  int unsigned step;
  int unsigned len;

  always_comb begin
    // default: unreachable addresses behave like the trap word
    word_o = '{asel: ASRC_NONE, dsel: DSRC_NONE, ir_ld: 1'b0, eoi: 1'b1,
               disp: 1'b0, trap: 1'b1, nxt: '0};
    rel  = 0;
    code = 0;
    step = 0;
    len  = 0;
    case (upc_i)
      UA_W'(0): begin
        word_o = '{asel: ASRC_IPTR, dsel: DSRC_MEM, ir_ld: 1'b1, eoi: 1'b0,
                   disp: 1'b0, trap: 1'b0, nxt: UA_W'(1)};
      end
      UA_W'(1): begin
        word_o = '{asel: ASRC_NONE, dsel: DSRC_NONE, ir_ld: 1'b0, eoi: 1'b0,
                   disp: 1'b1, trap: 1'b0, nxt: '0};
      end
      TRAP_ADDR: begin
        word_o = '{asel: ASRC_NONE, dsel: DSRC_NONE, ir_ld: 1'b0, eoi: 1'b1,
                   disp: 1'b0, trap: 1'b1, nxt: '0};
      end
      default: begin
        if (32'(upc_i) >= ENTRY_BASE && 32'(upc_i) < EXEC_END) begin
          rel  = 32'(upc_i) - ENTRY_BASE;
          code = rel / STRIDE;
          step = rel % STRIDE;
          len  = (code % STRIDE) + 1;
          if (step < len) begin
            word_o.asel  = ASRC_WPTR;
            word_o.dsel  = (step == len - 1) ? DSRC_RES : DSRC_AREG;
            word_o.ir_ld = 1'b0;
            word_o.eoi   = (step == len - 1);
            word_o.disp  = 1'b0;
            word_o.trap  = 1'b0;
            word_o.nxt   = (step == len - 1) ? '0 : UA_W'(32'(upc_i) + 1);
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int unsigned               CODE_W     = 4,
  parameter int unsigned               N_USED     = 12,
  parameter int unsigned               ENTRY_BASE = 16,
  parameter int unsigned               STRIDE     = 4,
  parameter logic [useq_pkg::UA_W-1:0] TRAP_ADDR  = 9'h1F0
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [UA_W-1:0]   entry_o
);
  localparam int unsigned N_CODES = 1 << CODE_W;

  logic [UA_W-1:0] tbl [N_CODES];

  for (genvar g = 0; g < N_CODES; g++) begin : g_tbl
    if (g < N_USED) begin : g_used
      assign tbl[g] = UA_W'(ENTRY_BASE + g * STRIDE);
    end else begin : g_trap
      assign tbl[g] = TRAP_ADDR;
    end
  end

  assign entry_o = tbl[code_i];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  uword_t          word_i,
  input  logic [UA_W-1:0] upc_i,
  input  logic [UA_W-1:0] entry_i,
  input  logic            rdy_i,
  output logic [UA_W-1:0] nxt_o
);
  always_comb begin
    if (word_i.disp)                 nxt_o = entry_i;
    else if (word_i.ir_ld && !rdy_i) nxt_o = upc_i;   // fetch stall
    else                             nxt_o = word_i.nxt;
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int unsigned               REG_W      = 32,
  parameter int unsigned               CODE_W     = 4,
  parameter int unsigned               N_USED     = 12,
  parameter int unsigned               ENTRY_BASE = 16,
  parameter int unsigned               STRIDE     = 4,
  parameter logic [useq_pkg::UA_W-1:0] TRAP_ADDR  = 9'h1F0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rdy_i,
  input  logic                        dec_src_i,
  input  logic [REG_W-1:0]            instr_i,
  input  logic [REG_W-1:0]            oprnd_i,
  output logic [useq_pkg::UA_W-1:0]   upc_o,
  output logic [1:0]                  asel_o,
  output logic [1:0]                  dsel_o,
  output logic                        ir_ld_o,
  output logic                        eoi_o,
  output logic                        err_o
);
  logic [UA_W-1:0]   upc_q;
  logic [UA_W-1:0]   upc_d;
  logic [UA_W-1:0]   entry;
  logic [CODE_W-1:0] code;
  logic              err_q;
  uword_t            word;

  logic unused_low;
  assign unused_low = ^{instr_i[REG_W-CODE_W-1:0], oprnd_i[REG_W-CODE_W-1:0]};

  assign code = dec_src_i ? oprnd_i[REG_W-1 -: CODE_W] : instr_i[REG_W-1 -: CODE_W];

  useq_rom #(
    .N_USED(N_USED), .ENTRY_BASE(ENTRY_BASE), .STRIDE(STRIDE), .TRAP_ADDR(TRAP_ADDR)
  ) u_rom (
    .upc_i (upc_q),
    .word_o(word)
  );

  useq_dispatch #(
    .CODE_W(CODE_W), .N_USED(N_USED), .ENTRY_BASE(ENTRY_BASE),
    .STRIDE(STRIDE), .TRAP_ADDR(TRAP_ADDR)
  ) u_disp (
    .code_i (code),
    .entry_o(entry)
  );

  useq_next u_next (
    .word_i (word),
    .upc_i  (upc_q),
    .entry_i(entry),
    .rdy_i  (rdy_i),
    .nxt_o  (upc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upc_q <= '0;
      err_q <= 1'b0;
    end else begin
      upc_q <= upc_d;
      if (word.trap) err_q <= 1'b1;
    end
  end

  assign upc_o   = upc_q;
  assign asel_o  = word.asel;
  assign dsel_o  = word.dsel;
  assign ir_ld_o = word.ir_ld & rdy_i;
  assign eoi_o   = word.eoi;
  assign err_o   = err_q;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter logic [8:0] TRAP_ADDR = 9'h1F0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rdy_i,
  input logic [8:0] upc_o,
  input logic       ir_ld_o,
  input logic       eoi_o,
  input logic       err_o
);
  a_r1_reset_state: assert property (@(posedge clk_i) !rst_ni |-> (upc_o == 9'd0 && !err_o));

  a_r2_fetch_to_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == 9'd0 && rdy_i) |=> upc_o == 9'd1);

  a_r2_load_only_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_ld_o |-> (upc_o == 9'd0 && rdy_i));

  a_r3_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == 9'd0 && !rdy_i) |=> upc_o == 9'd0);

  a_r4_decode_leaves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc_o == 9'd1 |=> (upc_o != 9'd0 && upc_o != 9'd1));

  a_r7_eoi_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |=> upc_o == 9'd0);

  a_r8_trap_sets_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc_o == TRAP_ADDR |=> err_o);

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind useq_ctrl useq_ctrl_chk #(.TRAP_ADDR(TRAP_ADDR)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rdy_i  (rdy_i),
  .upc_o  (upc_o),
  .ir_ld_o(ir_ld_o),
  .eoi_o  (eoi_o),
  .err_o  (err_o)
);

// File: tb/useq_ctrl_tb.sv
`timescale 1ns/1ps
module useq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rdy = 1'b1;
  logic        dec_src = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] oprnd = '0;
  logic [8:0]  upc;
  logic [1:0]  asel, dsel;
  logic        ir_ld, eoi, err;

  int n_chk = 0;
  int n_bad = 0;
  logic err_exp = 1'b0;

  typedef struct {
    logic [8:0] upc;
    logic [1:0] a;
    logic [1:0] d;
    logic       ir;
    logic       eoi;
    logic       err;
    string      req;
  } exp_t;

  exp_t q[$];

  always #2 clk = ~clk;

  useq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rdy_i(rdy), .dec_src_i(dec_src),
    .instr_i(instr), .oprnd_i(oprnd), .upc_o(upc), .asel_o(asel),
    .dsel_o(dsel), .ir_ld_o(ir_ld), .eoi_o(eoi), .err_o(err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [8:0] u, input logic [1:0] a, input logic [1:0] d,
                      input logic ir, input logic e, input string req);
    exp_t x;
    x.upc = u; x.a = a; x.d = d; x.ir = ir; x.eoi = e; x.err = err_exp; x.req = req;
    q.push_back(x);
  endtask

  // monitor: compare one expected item per cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "upc", 32'(upc), 32'(e.upc));
      chk(e.req, "asel", 32'(asel), 32'(e.a));
      chk(e.req, "dsel", 32'(dsel), 32'(e.d));
      chk(e.req, "ir_ld", 32'(ir_ld), 32'(e.ir));
      chk(e.req, "eoi", 32'(eoi), 32'(e.eoi));
      chk(e.req, "err", 32'(err), 32'(e.err));
    end
  end

  // driver: called just after the edge that enters fetch
  task automatic run(input logic [3:0] ci, input logic [3:0] co, input logic src,
                     input int stall, input logic rdy_low_exec);
    logic [3:0] c;
    int n;
    int len;
    logic is_trap;
    c = src ? co : ci;
    instr = {ci, 28'h5A3C1E7};
    oprnd = {co, 28'hE1C3A50};
    dec_src = src;
    rdy = (stall == 0);
    for (int s = 0; s < stall; s++) push(9'd0, 2'd1, 2'd1, 1'b0, 1'b0, "R3");
    push(9'd0, 2'd1, 2'd1, 1'b1, 1'b0, "R2");
    push(9'd1, 2'd0, 2'd0, 1'b0, 1'b0, src ? "R4_opsrc" : "R4");
    is_trap = (c >= 4'd12);
    if (!is_trap) begin
      len = int'(c) % 4 + 1;
      for (int s = 0; s < len; s++)
        push(9'(16 + 4 * int'(c) + s), 2'd2, (s == len - 1) ? 2'd3 : 2'd2, 1'b0,
             s == len - 1, (s == 0) ? "R5" : ((s == len - 1) ? "R7" : "R6"));
      n = stall + 2 + len;
    end else begin
      push(9'h1F0, 2'd0, 2'd0, 1'b0, 1'b1, "R8");
      n = stall + 3;
    end
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (i == stall - 1) rdy = 1'b1;
      if (i == stall && rdy_low_exec) rdy = 1'b0;  // R9: ignored outside fetch
    end
    if (is_trap) err_exp = 1'b1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "upc_rst", 32'(upc), 32'd0);
    chk("R1", "err_rst", 32'(err), 32'd0);
    chk("R2", "asel_rst", 32'(asel), 32'd1);
    chk("R2", "ir_ld_rst", 32'(ir_ld), 32'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int c = 0; c < 12; c++) run(4'(c), 4'(15 - c), 1'b0, 0, 1'b0);
    run(4'd3, 4'd9, 1'b0, 3, 1'b0);
    run(4'd2, 4'd7, 1'b0, 0, 1'b1);
    run(4'd13, 4'd1, 1'b1, 0, 1'b0);
    run(4'd0, 4'd11, 1'b1, 2, 1'b1);
    run(4'd12, 4'd0, 1'b0, 0, 1'b0);
    run(4'd5, 4'd6, 1'b1, 0, 1'b0);
    for (int c = 13; c < 16; c++) run(4'(c), 4'd0, 1'b0, 0, 1'b0);
    run(4'd9, 4'd14, 1'b1, 1, 1'b0);
    run(4'd4, 4'd1, 1'b0, 0, 1'b1);
    @(negedge clk);
    chk("R8", "queue_drained", 32'(q.size()), 32'd0);
    chk("R8", "err_sticky", 32'(err), 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R1", "upc_async_rst", 32'(upc), 32'd0);
    chk("R1", "err_cleared", 32'(err), 32'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog all act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule